// File: doc/BRIEF.md
# SDRAM Refresh and Power-State Sequencer

This block sits on the controller side of an SDRAM interface and owns the clock-enable line and the three command strobes whenever the memory has to be refreshed or put into a low-power state. It accepts a periodic refresh tick, a level request for self refresh and a level request for power-down. It also takes a flag from the bank tracker that says every bank is precharged. From these it decides when to issue an auto refresh, when to enter or leave self refresh, and when to drop into or come out of power-down.

A host arbiter sees a single `grant` line and may start access commands only while it is high. When `grant` falls, the arbiter closes its open rows, and the sequencer then waits for the idle flag to have held for the programmed precharge time. After a refresh or a self-refresh exit it keeps access blocked for the row-cycle time. It counts refresh ticks that arrive while access is blocked and pays each one back with an auto refresh before `grant` returns. While in power-down it watches its own residency and forces an exit before the refresh interval can lapse.

The precharge time, the row-cycle time and the power-down residency limit are run-time inputs in clock cycles. The row-cycle count must be at least 2 and the residency limit at least 1.

Top module: `sdr_pwr_seq`

## Requirements
- R1: While reset is held, `cke` is 1, `{ras_n,cas_n,we_n}` is 3'b111, and `grant` and `busy` are 0.
- R2: The command pins only ever carry the no-operation code 3'b111 or the refresh code 3'b001 (order `{ras_n,cas_n,we_n}`), shown for exactly one cycle per refresh.
- R3: An auto refresh (code 3'b001 with `cke` high) is issued only at a clock edge where `banks_idle` is high and was sampled high on at least `trp_cyc` consecutive earlier edges. With `banks_idle` first sampled high at edge E0 together with the first tick, the command appears after edge E0+max(1,`trp_cyc`). With `banks_idle` low no refresh is issued.
- R4: Any two refresh commands are at least `trc_cyc` cycles apart. `grant` rises `trc_cyc`-1 cycles after the cycle in which an auto refresh is shown, when nothing else is pending.
- R5: Ticks sampled while in any state except self refresh are counted. Each counted tick is served by one auto refresh before `grant` rises, and a pending refresh is served before a self-refresh or power-down entry is taken.
- R6: Self refresh entry shows the refresh code in the same cycle that `cke` falls, one cycle after `selfref_req` is sampled with the idle condition met and nothing pending. `cke` stays low until `selfref_req` is sampled low, and it is high in the following cycle.
- R7: Ticks sampled during self refresh are discarded. After the exit, no auto refresh follows, and `grant` rises `trc_cyc`-1 cycles after the first cycle with `cke` high.
- R8: Power-down entry drives `cke` low with the no-operation code one cycle after `pwrdn_req` is sampled with the idle condition met. When `pwrdn_req` is sampled low, `cke` is high in the next cycle and `grant` one cycle after that.
- R9: `cke` stays low in power-down for at most `pd_max_cyc` consecutive cycles. If `pwrdn_req` is still high after a forced exit, `cke` is high for exactly two cycles before the next entry.
- R10: `busy` is high while a refresh, self-refresh or power-down sequence runs, and falls in the same cycle as `grant` rises after an auto refresh. `busy` and `grant` are never high together.
- R11: `grant` is high only when no sequence runs, no refresh is pending, and neither power request is high; it is never high while `cke` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_tick | input | 1 | One-cycle pulse per refresh interval |
| selfref_req | input | 1 | Level request to stay in self refresh |
| pwrdn_req | input | 1 | Level request to stay in power-down |
| banks_idle | input | 1 | All banks are precharged |
| trp_cyc | input | CNT_W | Precharge time in cycles |
| trc_cyc | input | CNT_W | Row-cycle time in cycles (at least 2) |
| pd_max_cyc | input | PD_W | Largest power-down residency in cycles (at least 1) |
| cke | output | 1 | Clock enable to the memory |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| grant | output | 1 | Host may issue access commands |
| busy | output | 1 | A refresh or power-state sequence is running |

## Verification
Every output is registered, so each result is due a whole number of edges after the edge that samples its cause. An auto refresh is due max(1,`trp_cyc`) edges after the idle flag and tick are first seen. `grant` follows the refresh by `trc_cyc`-1 cycles. A power-state change shows one edge after the request is sampled, and `grant` returns two edges after a power-down request drops. The bench drives inputs and samples outputs on falling edges, and it keeps a free-running count of rising edges. It records that count when it applies a stimulus and again when the awaited output first appears, and it compares the difference against the latency computed from the programmed cycle counts. This is done across sweeps of `trc_cyc`, `trp_cyc` and `pd_max_cyc`.

// File: rtl/sdr_pwr_pkg.sv
package sdr_pwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AREF,
        ST_SREF,
        ST_SRX,
        ST_PDN,
        ST_PDX
    } seq_st_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

    localparam cmd_t CMD_NOP = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_t CMD_REF = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/sdr_idle_timer.sv
// Counts consecutive edges with all banks idle and qualifies them against tRP.
module sdr_idle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             banks_idle,
    input  logic [CNT_W-1:0] trp_cyc,
    output logic             idle_ok
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!banks_idle) begin
            run_d = '0;
        end else if (run_q != CNT_MAX) begin
            run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assign idle_ok = banks_idle && (run_q >= trp_cyc);

endmodule

// File: rtl/sdr_ref_pend.sv
// Saturating count of refresh ticks that still owe an auto refresh.
module sdr_ref_pend #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic discard,
    input  logic serve,
    output logic none_q,
    output logic none_d
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    logic [PEND_W-1:0] owed_d, owed_q;
    logic              add;

    always_comb begin
        add    = tick && !discard && ((owed_q != PEND_MAX) || serve);
        owed_d = owed_q;
        case ({add, serve})
            2'b10:   owed_d = owed_q + 1'b1;
            2'b01:   owed_d = owed_q - 1'b1;
            default: owed_d = owed_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else begin
            owed_q <= owed_d;
        end
    end

    assign none_q = (owed_q == '0);
    assign none_d = (owed_d == '0);

endmodule

// File: rtl/sdr_pwr_seq.sv
// Refresh and power-state sequencer: owns CKE and the command strobes.
module sdr_pwr_seq
    import sdr_pwr_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PD_W   = 16,
    parameter int PEND_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh_tick,
    input  logic             selfref_req,
    input  logic             pwrdn_req,
    input  logic             banks_idle,
    input  logic [CNT_W-1:0] trp_cyc,
    input  logic [CNT_W-1:0] trc_cyc,
    input  logic [PD_W-1:0]  pd_max_cyc,
    output logic             cke,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             grant,
    output logic             busy
);
    localparam int PDX_W = PD_W + 1;

    typedef struct packed {
        seq_st_e          st;
        logic             cke;
        cmd_t             cmd;
        logic [CNT_W-1:0] tmr;
        logic [PD_W-1:0]  pdc;
        logic             grant;
        logic             busy;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    logic idle_ok;
    logic none_q, none_d;
    logic serve, discard;
    logic pd_limit;

    sdr_idle_timer #(.CNT_W(CNT_W)) idle_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .banks_idle (banks_idle),
        .trp_cyc    (trp_cyc),
        .idle_ok    (idle_ok)
    );

    sdr_ref_pend #(.PEND_W(PEND_W)) pend_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (refresh_tick),
        .discard (discard),
        .serve   (serve),
        .none_q  (none_q),
        .none_d  (none_d)
    );

    assign pd_limit = ({1'b0, cur_q.pdc} + PDX_W'(1)) >= {1'b0, pd_max_cyc};

    always_comb begin
        nxt_d   = cur_q;
        nxt_d.cmd = CMD_NOP;
        serve   = 1'b0;
        discard = 1'b0;

        case (cur_q.st)
            ST_IDLE: begin
                if (!none_q && idle_ok) begin
                    serve     = 1'b1;
                    nxt_d.st  = ST_AREF;
                    nxt_d.cmd = CMD_REF;
                    nxt_d.tmr = trc_cyc - 1'b1;
                end else if (selfref_req && idle_ok && none_q) begin
                    nxt_d.st  = ST_SREF;
                    nxt_d.cmd = CMD_REF;
                    nxt_d.cke = 1'b0;
                end else if (pwrdn_req && idle_ok && none_q) begin
                    nxt_d.st  = ST_PDN;
                    nxt_d.cke = 1'b0;
                    nxt_d.pdc = '0;
                end
            end
            ST_AREF, ST_SRX: begin
                if (cur_q.tmr != '0) begin
                    nxt_d.tmr = cur_q.tmr - 1'b1;
                end
                if (cur_q.tmr <= CNT_W'(1)) begin
                    nxt_d.st = ST_IDLE;
                end
            end
            ST_SREF: begin
                discard = 1'b1;
                if (!selfref_req) begin
                    nxt_d.st  = ST_SRX;
                    nxt_d.cke = 1'b1;
                    nxt_d.tmr = trc_cyc - 1'b1;
                end
            end
            ST_PDN: begin
                nxt_d.pdc = cur_q.pdc + 1'b1;
                if (!pwrdn_req || pd_limit) begin
                    nxt_d.st  = ST_PDX;
                    nxt_d.cke = 1'b1;
                end
            end
            ST_PDX: begin
                nxt_d.st = ST_IDLE;
            end
            default: begin
                nxt_d.st  = ST_IDLE;
                nxt_d.cke = 1'b1;
            end
        endcase

        nxt_d.busy  = (nxt_d.st != ST_IDLE);
        nxt_d.grant = (nxt_d.st == ST_IDLE) && none_d && !selfref_req && !pwrdn_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st    <= ST_IDLE;
            cur_q.cke   <= 1'b1;
            cur_q.cmd   <= CMD_NOP;
            cur_q.tmr   <= '0;
            cur_q.pdc   <= '0;
            cur_q.grant <= 1'b0;
            cur_q.busy  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cke   = cur_q.cke;
    assign ras_n = cur_q.cmd.ras_n;
    assign cas_n = cur_q.cmd.cas_n;
    assign we_n  = cur_q.cmd.we_n;
    assign grant = cur_q.grant;
    assign busy  = cur_q.busy;

endmodule

// File: rtl/sdr_pwr_seq_chk.sv
module sdr_pwr_seq_chk #(
    parameter int CNT_W = 8,
    parameter int PD_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             banks_idle,
    input logic [CNT_W-1:0] trc_cyc,
    input logic [PD_W-1:0]  pd_max_cyc,
    input logic             cke,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             grant,
    input logic             busy
);
    logic        is_ref;
    int unsigned since_q;
    logic        seen_q;
    logic        sr_q;
    int unsigned low_q;

    assign is_ref = !ras_n && !cas_n && we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= 0;
            seen_q  <= 1'b0;
            sr_q    <= 1'b0;
            low_q   <= 0;
        end else begin
            if (is_ref) begin
                since_q <= 1;
                seen_q  <= 1'b1;
            end else if (since_q != 32'hFFFF_FFFF) begin
                since_q <= since_q + 1;
            end
            sr_q  <= cke ? 1'b0 : (sr_q || is_ref);
            low_q <= cke ? 0 : ((low_q != 32'hFFFF_FFFF) ? low_q + 1 : low_q);
        end
    end

    // R2
    cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({ras_n, cas_n, we_n} == 3'b111) || is_ref);

    // R3
    ref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> $past(banks_idle));

    // R4
    ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && seen_q) |-> (since_q >= 32'(trc_cyc)));

    // R6
    sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && !cke) |-> $past(cke));

    // R8
    wake_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> !grant);

    // R9
    pd_residency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !sr_q && !is_ref) |-> (low_q < 32'(pd_max_cyc)));

    // R10
    busy_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && grant));

    // R11
    grant_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !grant);

endmodule

bind sdr_pwr_seq sdr_pwr_seq_chk #(.CNT_W(CNT_W), .PD_W(PD_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .banks_idle (banks_idle),
    .trc_cyc    (trc_cyc),
    .pd_max_cyc (pd_max_cyc),
    .cke        (cke),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .grant      (grant),
    .busy       (busy)
);

// File: tb/sdr_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module sdr_pwr_seq_tb_top;
    localparam int CNT_W = 8;
    localparam int PD_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             sr = 1'b0;
    logic             pd = 1'b0;
    logic             bidle = 1'b0;
    logic [CNT_W-1:0] trp = '0;
    logic [CNT_W-1:0] trc = 8'd2;
    logic [PD_W-1:0]  pdmax = 16'd4;
    logic cke, ras_n, cas_n, we_n, grant, busy;

    int pc = 0;
    int nvec = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) pc <= pc + 1;

    sdr_pwr_seq #(.CNT_W(CNT_W), .PD_W(PD_W), .PEND_W(4)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .refresh_tick (tick),
        .selfref_req  (sr),
        .pwrdn_req    (pd),
        .banks_idle   (bidle),
        .trp_cyc      (trp),
        .trc_cyc      (trc),
        .pd_max_cyc   (pdmax),
        .cke          (cke),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .grant        (grant),
        .busy         (busy)
    );

    function automatic logic cond(input int kind);
        logic rf;
        rf = !ras_n && !cas_n && we_n;
        case (kind)
            0:       return cke && rf;
            1:       return grant;
            2:       return !cke;
            3:       return cke;
            4:       return !cke && rf;
            default: return 1'b0;
        endcase
    endfunction

    task automatic wait_cond(input int kind, output int at);
        at = -1;
        for (int i = 0; i < 300; i++) begin
            if (cond(kind)) begin
                at = pc;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic count_window(input int kind, input int len, output int hits);
        hits = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (cond(kind)) hits++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        int p0, a, b, q, h;
        repeat (3) @(negedge clk);
        chk("R1 cke in reset", int'(cke), 1);
        chk("R1 cmd in reset", int'({ras_n, cas_n, we_n}), 7);
        chk("R1 grant in reset", int'(grant), 0);
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 grant after reset", int'(grant), 1);

        // R3 R4 R10: auto refresh latency sweep over tRC and tRP
        for (int vc = 2; vc <= 5; vc++) begin
            for (int vp = 0; vp <= 3; vp++) begin
                bidle = 1'b0;
                trc = CNT_W'(vc);
                trp = CNT_W'(vp);
                repeat (3) @(negedge clk);
                tick = 1'b1;
                bidle = 1'b1;
                @(negedge clk);
                tick = 1'b0;
                p0 = pc;
                wait_cond(0, a);
                chk("R3 refresh issue edge", a - p0, (vp > 1) ? vp : 1);
                chk("R10 busy during refresh", int'(busy), 1);
                @(negedge clk);
                chk("R2 refresh one cycle", int'(cond(0)), 0);
                wait_cond(1, b);
                chk("R4 grant after refresh", b - a, vc - 1);
                chk("R10 busy falls with grant", int'(busy), 0);
            end
        end

        // R4 R5: two counted ticks, back-to-back refreshes
        trp = '0;
        for (int vc = 2; vc <= 5; vc++) begin
            trc = CNT_W'(vc);
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            p0 = pc;
            @(negedge clk);
            tick = 1'b0;
            wait_cond(0, a);
            chk("R5 first of two refreshes", a - p0, 1);
            @(negedge clk);
            wait_cond(0, b);
            chk("R4 refresh spacing", b - a, vc);
            @(negedge clk);
            wait_cond(1, q);
            chk("R5 grant after both served", q - b, vc - 1);
        end

        // R6 R7: self refresh entry, ignored tick, exit
        for (int vc = 2; vc <= 5; vc++) begin
            trc = CNT_W'(vc);
            repeat (3) @(negedge clk);
            sr = 1'b1;
            @(negedge clk);
            p0 = pc;
            wait_cond(4, a);
            chk("R6 self refresh entry edge", a - p0, 0);
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            repeat (3) @(negedge clk);
            chk("R6 cke held low", int'(cke), 0);
            chk("R11 no grant in self refresh", int'(grant), 0);
            sr = 1'b0;
            q = pc;
            wait_cond(3, a);
            chk("R6 cke high after exit", a - q, 1);
            wait_cond(1, b);
            chk("R7 grant after self refresh exit", b - a, vc - 1);
            count_window(0, 10, h);
            chk("R7 tick in self refresh dropped", h, 0);
        end

        // R8 R9: forced power-down exit and re-entry, then voluntary exit
        trc = 8'd3;
        for (int vm = 1; vm <= 4; vm++) begin
            pdmax = PD_W'(vm);
            repeat (3) @(negedge clk);
            pd = 1'b1;
            @(negedge clk);
            p0 = pc;
            chk("R8 cke low on entry", int'(cke), 0);
            chk("R8 NOP on entry", int'({ras_n, cas_n, we_n}), 7);
            wait_cond(3, a);
            chk("R9 residency limit", a - p0, vm);
            wait_cond(2, b);
            chk("R9 high gap before re-entry", b - a, 2);
            pd = 1'b0;
            q = pc;
            wait_cond(3, a);
            chk("R8 cke high after request drop", a - q, 1);
            wait_cond(1, b);
            chk("R8 grant one cycle after wake", b - a, 1);
        end

        // R5: tick during power-down is served after exit
        pdmax = 16'd40;
        trc = 8'd3;
        repeat (3) @(negedge clk);
        pd = 1'b1;
        repeat (2) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (2) @(negedge clk);
        pd = 1'b0;
        q = pc;
        wait_cond(0, a);
        chk("R5 refresh after power-down exit", a - q, 3);
        wait_cond(1, b);
        chk("R5 grant after owed refresh", b - a, 2);

        // R5: pending refresh goes before self refresh entry
        trc = 8'd4;
        repeat (3) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        p0 = pc;
        tick = 1'b0;
        sr = 1'b1;
        wait_cond(0, a);
        chk("R5 refresh before self refresh", a - p0, 1);
        wait_cond(4, b);
        chk("R5 self refresh after tRC", b - a, 4);
        sr = 1'b0;
        wait_cond(1, q);

        // R3 R11: banks not idle blocks refresh and grant
        bidle = 1'b0;
        trp = 8'd2;
        trc = 8'd2;
        repeat (3) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        count_window(0, 10, h);
        chk("R3 no refresh while banks busy", h, 0);
        chk("R11 grant low while refresh owed", int'(grant), 0);
        bidle = 1'b1;
        q = pc;
        wait_cond(0, a);
        chk("R3 refresh after tRP of idle", a - q, 3);
        wait_cond(1, b);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule